// File: doc/BRIEF.md
# Tournament Branch Predictor

This block predicts the direction of conditional branches by running two complete predictors side by side and letting a third table pick between them. The first predictor is driven by a shift register that holds the outcomes of the most recent branches, whichever branches they were. Its 12-bit value indexes a table of 2-bit saturating counters. The second predictor works in two levels. PC bits select a 10-bit history of the branches that map to that slot, and that history then indexes a table of 3-bit saturating counters. A chooser table of 2-bit counters, indexed by the same recent-outcome register, decides which of the two predictors supplies the final answer.

The fetch side is purely combinational. The front end presents a fetch PC and reads the final prediction and both component predictions in the same cycle. When the branch resolves, the pipeline presents the branch PC, the actual direction and the two component predictions it captured at fetch, together with an update strobe. On that clock edge the block trains both counter tables and the chooser, then shifts the outcome into the recent-outcome register and into the addressed per-branch history. The update uses the history state as it stands when the update arrives, so it is exact when no other branch resolves between the fetch and the update of a branch. With the default sizes the tables hold 4K×2 + 4K×2 + 1K×10 + 1K×3 bits.

Top module: `tournPredictor`

## Requirements
- R1: After reset every 2-bit counter holds 1, every 3-bit counter holds 3, and all history bits are 0. All three prediction outputs are therefore 0 for any fetch PC.
- R2: The final prediction equals the global component when the chooser counter addressed by the global history is 2 or more. Otherwise it equals the local component.
- R3: The global component is taken when the 2-bit counter indexed by the 12-bit global history is 2 or more. On an update that counter moves one step toward the outcome and saturates at 0 and 3.
- R4: On an update the outcome is shifted into bit 0 of the global history (1 = taken). Bit i then holds the outcome of the branch resolved i updates earlier, and the oldest bit is dropped.
- R5: The per-branch history table has 1024 entries of 10 bits, indexed by PC bits [11:2]. PCs that differ only outside those bits share an entry. On an update the outcome is shifted into bit 0 of the addressed entry.
- R6: The local component is taken when the 3-bit counter indexed by the fetch PC's per-branch history is 4 or more. On an update the counter indexed by the updated branch's history, taken before the shift, moves one step toward the outcome and saturates at 0 and 7.
- R7: The chooser counter indexed by the global history increments, saturating at 3, when only the global component was right. It decrements, saturating at 0, when only the local component was right. It is unchanged when both were right or both were wrong.
- R8: The prediction outputs reflect the state before any update on the same clock edge. An update becomes visible to fetches from the following cycle on.
- R9: While the update strobe is low, no table and no history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | 32 | PC of the branch being fetched |
| predTaken | output | 1 | Final prediction (1 = taken) |
| predGlobal | output | 1 | Global component prediction |
| predLocal | output | 1 | Local component prediction |
| updValid | input | 1 | Resolution strobe |
| updPc | input | 32 | PC of the resolved branch |
| updTaken | input | 1 | Actual outcome (1 = taken) |
| updPredGlobal | input | 1 | Global component prediction captured at fetch |
| updPredLocal | input | 1 | Local component prediction captured at fetch |

## Verification
On every cycle the assertions check that each counter steps by exactly one and holds at its limits, that an entry stays put when its table is not written, that both histories shift in the resolved outcome, that the global history holds still without an update, and that the final prediction follows the components whenever they agree. How well the block learns depends on long chains of updates: loop exits, alternating patterns, PCs that alias onto one history entry, and the chooser drifting toward whichever predictor is right. The bench's scenarios show this by comparing every fetch against a behavioural model built from the requirements, with hand-worked values at the end of a warm-up run.

// File: rtl/tournPkg.sv
package tournPkg;

  // Strobes the control sends to the datapath for one resolution
  typedef struct packed {
    logic gCtrWr;     // train the global counter
    logic lCtrWr;     // train the local counter
    logic histShift;  // shift the outcome into both histories
    logic chsWr;      // train the chooser
    logic chsUp;      // chooser direction: 1 toward global
    logic outcome;    // resolved direction
  } updStrb_t;

endpackage

// File: rtl/ctrTable.sv
module ctrTable #(
  parameter int IDX_W = 12,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdTaken,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             incDir
);
  localparam int DEPTH = 2 ** IDX_W;
  localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] INIT_V = MAX_V >> 1;  // weakly not taken / weakly local

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] wrOld;

  assign wrOld   = mem[wrIdx];
  assign rdTaken = mem[rdIdx][CNT_W-1];  // upper half of the range

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_V;
    end else if (wrEn) begin
      if (incDir && wrOld != MAX_V)       mem[wrIdx] <= wrOld + CNT_W'(1);
      else if (!incDir && wrOld != '0)    mem[wrIdx] <= wrOld - CNT_W'(1);
    end
  end

  // R3 R6 R7
  ctr_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && incDir && wrOld != MAX_V) |=> mem[$past(wrIdx)] == $past(wrOld) + CNT_W'(1));
  // R3 R6 R7
  ctr_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !incDir && wrOld != '0) |=> mem[$past(wrIdx)] == $past(wrOld) - CNT_W'(1));
  // R3 R6 R7
  ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && incDir && wrOld == MAX_V) |=> mem[$past(wrIdx)] == MAX_V);
  // R3 R6 R7
  ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !incDir && wrOld == '0) |=> mem[$past(wrIdx)] == '0);
  // R7 R9
  ctr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> mem[$past(wrIdx)] == $past(wrOld));

endmodule

// File: rtl/tournCtrl.sv
module tournCtrl
  import tournPkg::*;
(
  input  logic     updValid,
  input  logic     updTaken,
  input  logic     updPredGlobal,
  input  logic     updPredLocal,
  output updStrb_t strb
);
  logic globalRight;
  logic localRight;

  assign globalRight = (updPredGlobal == updTaken);
  assign localRight  = (updPredLocal == updTaken);

  always_comb begin
    strb           = '0;
    strb.outcome   = updTaken;
    strb.gCtrWr    = updValid;
    strb.lCtrWr    = updValid;
    strb.histShift = updValid;
    // chooser learns only from disagreement in correctness
    strb.chsWr     = updValid && (globalRight != localRight);
    strb.chsUp     = globalRight;
  end

endmodule

// File: rtl/tournDatapath.sv
module tournDatapath
  import tournPkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int GH_W     = 12,
  parameter int LIDX_W   = 10,
  parameter int LH_W     = 10,
  parameter int G_CNT_W  = 2,
  parameter int L_CNT_W  = 3,
  parameter int CH_CNT_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] updPc,
  input  updStrb_t        strb,
  output logic            predGlobal,
  output logic            predLocal,
  output logic            useGlobal
);
  localparam int LH_DEPTH = 2 ** LIDX_W;
  localparam int IDX_TOP  = PC_LSB + LIDX_W;

  logic [GH_W-1:0]   gHist;
  logic [LH_W-1:0]   lHistTbl [LH_DEPTH];
  logic [LIDX_W-1:0] fetchLIdx;
  logic [LIDX_W-1:0] updLIdx;
  logic [LH_W-1:0]   lhFetch;
  logic [LH_W-1:0]   lhUpd;
  logic              unusedPcBits;

  assign fetchLIdx    = fetchPc[PC_LSB +: LIDX_W];
  assign updLIdx      = updPc[PC_LSB +: LIDX_W];
  assign lhFetch      = lHistTbl[fetchLIdx];
  assign lhUpd        = lHistTbl[updLIdx];
  assign unusedPcBits = ^{fetchPc[PC_W-1:IDX_TOP], fetchPc[PC_LSB-1:0],
                          updPc[PC_W-1:IDX_TOP], updPc[PC_LSB-1:0]};

  // Global history register, newest outcome in bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gHist <= '0;
    else if (strb.histShift) gHist <= {gHist[GH_W-2:0], strb.outcome};
  end

  // Per-branch history table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LH_DEPTH; i++) lHistTbl[i] <= '0;
    end else if (strb.histShift) begin
      lHistTbl[updLIdx] <= {lhUpd[LH_W-2:0], strb.outcome};
    end
  end

  ctrTable #(.IDX_W(GH_W), .CNT_W(G_CNT_W)) gTbl (
    .clk(clk), .rstN(rstN),
    .rdIdx(gHist), .rdTaken(predGlobal),
    .wrEn(strb.gCtrWr), .wrIdx(gHist), .incDir(strb.outcome)
  );

  ctrTable #(.IDX_W(LH_W), .CNT_W(L_CNT_W)) lTbl (
    .clk(clk), .rstN(rstN),
    .rdIdx(lhFetch), .rdTaken(predLocal),
    .wrEn(strb.lCtrWr), .wrIdx(lhUpd), .incDir(strb.outcome)
  );

  ctrTable #(.IDX_W(GH_W), .CNT_W(CH_CNT_W)) chTbl (
    .clk(clk), .rstN(rstN),
    .rdIdx(gHist), .rdTaken(useGlobal),
    .wrEn(strb.chsWr), .wrIdx(gHist), .incDir(strb.chsUp)
  );

  // R4
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.histShift |=> gHist == {$past(gHist[GH_W-2:0]), $past(strb.outcome)});
  // R9
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.histShift |=> $stable(gHist));
  // R5
  lhist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.histShift |=> lHistTbl[$past(updLIdx)] == {$past(lhUpd[LH_W-2:0]), $past(strb.outcome)});

endmodule

// File: rtl/tournPredictor.sv
module tournPredictor
  import tournPkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int GH_W     = 12,
  parameter int LIDX_W   = 10,
  parameter int LH_W     = 10,
  parameter int G_CNT_W  = 2,
  parameter int L_CNT_W  = 3,
  parameter int CH_CNT_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic            predGlobal,
  output logic            predLocal,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updPredGlobal,
  input  logic            updPredLocal
);
  updStrb_t strb;
  logic     useGlobal;

  tournCtrl ctrl (
    .updValid(updValid), .updTaken(updTaken),
    .updPredGlobal(updPredGlobal), .updPredLocal(updPredLocal),
    .strb(strb)
  );

  tournDatapath #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .GH_W(GH_W), .LIDX_W(LIDX_W), .LH_W(LH_W),
    .G_CNT_W(G_CNT_W), .L_CNT_W(L_CNT_W), .CH_CNT_W(CH_CNT_W)
  ) dp (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .updPc(updPc), .strb(strb),
    .predGlobal(predGlobal), .predLocal(predLocal), .useGlobal(useGlobal)
  );

  assign predTaken = useGlobal ? predGlobal : predLocal;

  // R2
  agree_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predGlobal == predLocal) |-> (predTaken == predGlobal));
  // R2
  pick_member_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predTaken == predGlobal) || (predTaken == predLocal));

endmodule

// File: tb/tb_tournPredictor.sv
`timescale 1ns/1ps
module tb_tournPredictor;
  localparam int GH_W = 12;
  localparam int LH_W = 10;
  localparam int G_DEPTH = 1 << GH_W;
  localparam int L_DEPTH = 1 << LH_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predTaken, predGlobal, predLocal;
  logic        updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic        updTaken = 1'b0;
  logic        updPredGlobal = 1'b0;
  logic        updPredLocal = 1'b0;

  int checkCount = 0;
  int failCount  = 0;

  // behavioural model state
  int gCtrM [G_DEPTH];
  int chM   [G_DEPTH];
  int lCtrM [L_DEPTH];
  int lHistM[L_DEPTH];
  int gHistM;

  always #2.5 clk = ~clk;

  tournPredictor dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .predTaken(predTaken), .predGlobal(predGlobal), .predLocal(predLocal),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
    .updPredGlobal(updPredGlobal), .updPredLocal(updPredLocal)
  );

  task automatic check(input logic act, input logic exp, input string msg);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0b expected %0b", msg, act, exp);
    end
  endtask

  function automatic int lIdx(input logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < G_DEPTH; i++) begin gCtrM[i] = 1; chM[i] = 1; end
    for (int i = 0; i < L_DEPTH; i++) begin lCtrM[i] = 3; lHistM[i] = 0; end
    gHistM = 0;
  endtask

  task automatic modelPredict(input logic [31:0] pc, output logic pg, output logic pl, output logic pt);
    pg = (gCtrM[gHistM] >= 2);
    pl = (lCtrM[lHistM[lIdx(pc)]] >= 4);
    pt = (chM[gHistM] >= 2) ? pg : pl;
  endtask

  task automatic modelUpdate(input logic [31:0] pc, input logic taken, input logic pg, input logic pl);
    int li, lh;
    li = lIdx(pc);
    lh = lHistM[li];
    if (taken) begin
      if (gCtrM[gHistM] < 3) gCtrM[gHistM]++;
      if (lCtrM[lh] < 7) lCtrM[lh]++;
    end else begin
      if (gCtrM[gHistM] > 0) gCtrM[gHistM]--;
      if (lCtrM[lh] > 0) lCtrM[lh]--;
    end
    if (pg == taken && pl != taken && chM[gHistM] < 3) chM[gHistM]++;
    else if (pl == taken && pg != taken && chM[gHistM] > 0) chM[gHistM]--;
    gHistM = ((gHistM << 1) | int'(taken)) & (G_DEPTH - 1);
    lHistM[li] = ((lh << 1) | int'(taken)) & (L_DEPTH - 1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; updValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  // One fetch plus its resolution in the same cycle: outputs must show pre-update state (R8)
  task automatic step(input logic [31:0] pc, input logic taken);
    logic pg, pl, pt;
    @(negedge clk);
    modelPredict(pc, pg, pl, pt);
    fetchPc = pc;
    updValid = 1'b1; updPc = pc; updTaken = taken;
    updPredGlobal = pg; updPredLocal = pl;
    #1;
    check(predGlobal, pg, "R3 R4 R8 global component");
    check(predLocal,  pl, "R5 R6 R8 local component");
    check(predTaken,  pt, "R2 R7 final prediction");
    @(posedge clk);
    modelUpdate(pc, taken, pg, pl);
    #1 updValid = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      fetchPc = 32'h0000_1000 * i + 32'h0000_0044 * i;
      #1;
      check(predGlobal, 1'b0, "R1 global after reset");
      check(predLocal,  1'b0, "R1 local after reset");
      check(predTaken,  1'b0, "R1 final after reset");
    end
  endtask

  task automatic testWarmUp();
    doReset();
    for (int i = 0; i < 20; i++) step(32'h0000_0400, 1'b1);
    // hand-worked: global counter at history all-ones reached 3, local counter at 0x3FF reached 7,
    // chooser there fell to 0 when only the local side was right
    @(negedge clk);
    fetchPc = 32'h0000_0400;
    #1;
    check(predGlobal, 1'b1, "R3 global learned taken");
    check(predLocal,  1'b1, "R6 local learned taken");
    check(predTaken,  1'b1, "R2 final learned taken");
  endtask

  task automatic testIgnore();
    logic pg, pl, pt;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      updValid = 1'b0;
      updPc = 32'h0000_0400 + 32'(i * 4);
      updTaken = i[0];
      updPredGlobal = ~i[0];
      updPredLocal = i[1];
      fetchPc = 32'h0000_0400;
      #1;
      modelPredict(fetchPc, pg, pl, pt);
      check(predGlobal, pg, "R9 global unchanged without strobe");
      check(predLocal,  pl, "R9 local unchanged without strobe");
      check(predTaken,  pt, "R9 final unchanged without strobe");
    end
    for (int i = 0; i < 4; i++) step(32'h0000_0400, 1'b0);
  endtask

  task automatic testLoop();
    doReset();
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 9; i++) step(32'h0000_0810, 1'b1);
      step(32'h0000_0810, 1'b0);
    end
  endtask

  task automatic testAlternate();
    doReset();
    for (int i = 0; i < 80; i++) begin
      step(32'h0000_0120, i[0]);
      step(32'h0000_0240, 1'b0);
    end
  endtask

  task automatic testSaturate();
    doReset();
    for (int i = 0; i < 30; i++) step(32'h0000_0abc, 1'b0);
    for (int i = 0; i < 30; i++) step(32'h0000_0abc, 1'b1);
    for (int i = 0; i < 12; i++) step(32'h0000_0abc, 1'b0);
  endtask

  task automatic testAlias();
    logic pg, pl, pt;
    doReset();
    for (int i = 0; i < 16; i++) step(32'h0000_0330, 1'b1);
    // same PC bits [11:2], different upper bits: shares the history entry
    @(negedge clk);
    fetchPc = 32'h0001_0330;
    #1;
    modelPredict(fetchPc, pg, pl, pt);
    check(predLocal, pl, "R5 aliased PC shares local history");
    check(predLocal, 1'b1, "R5 aliased PC sees trained history");
    for (int i = 0; i < 10; i++) step(32'h0001_0330, i[1]);
    for (int i = 0; i < 10; i++) step(32'h0000_0334, ~i[0]);
  endtask

  task automatic testChooser();
    doReset();
    // pattern where global correlation helps: branch B repeats branch A's outcome
    for (int i = 0; i < 60; i++) begin
      step(32'h0000_0500, i[2] ^ i[0]);
      step(32'h0000_0600, i[2] ^ i[0]);
      step(32'h0000_0700, 1'b1);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    testReset();
    testWarmUp();
    testIgnore();
    testLoop();
    testAlternate();
    testSaturate();
    testAlias();
    testChooser();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule